// File: doc/BRIEF.md
# Host Controller Setup and Enable Registers

This block is the register front end of a host-attached storage controller. Software programs it over a simple 32-bit read/write bus. It holds the following registers:

- a read-only capability word and a version word;
- an interrupt mask, reached through separate set and clear offsets;
- a configuration word and a status word;
- an admin-queue size word;
- the 64-bit base addresses of the admin submission and completion rings.

Writing the configuration word is what drives the controller. When the enable bit rises, the block checks the whole setup in the same cycle. A good setup raises ready and sends a one-cycle start pulse to the queue engines. A bad setup raises the fatal status bit instead. When enable falls, ready drops and a one-cycle reset pulse goes out.

On a good enable the block latches the derived values that the queue logic uses:

- the memory page shift;
- the submission and completion entry sizes in bytes;
- the admin ring depths.

Shutdown requests are acknowledged at once, with no delay.

Top module: `hctl_regs`

## Requirements
- R1: After reset, the configuration, status, mask, size and base registers read 0, and ready, admin_start and ctl_reset are 0.
- R2: The capability word reads 0x0F0107FF at offset 0x00 and 0x00400020 at offset 0x04 with default parameters. The fields are:
  - max entries minus one in bits 15:0;
  - contiguous-ring-required in bit 16;
  - timeout in bits 31:24;
  - command set bit 37;
  - minimum page exponent in bits 51:48;
  - maximum page exponent in bits 55:52.

  The version word at 0x08 reads 0x00010100.
- R3: A write to 0x0C ORs its data into the interrupt mask. A write to 0x10 clears the written bits. Both offsets read back the same mask, which is also driven on irq_mask.
- R4: A configuration write (offset 0x14) that raises enable (bit 0) with a valid setup sets the status word (offset 0x1C) to exactly 0x1 (ready, bit 0). It also pulses admin_start high for exactly one cycle, in the cycle after the write.
- R5: Raising enable fails validation, sets the status word to exactly 0x2 (fatal, bit 1) and gives no admin_start pulse, when any of the following holds:
  - either admin base is zero;
  - either admin base is not aligned to the page size of 2^(12+page exponent) bytes, the page exponent being configuration bits 10:7;
  - the page exponent lies outside the capability range (0..4);
  - the submission entry exponent (bits 19:16) is not 6;
  - the completion entry exponent (bits 23:20) is not 4;
  - either size field is zero. The size word at 0x24 holds the submission size in bits 11:0 and the completion size in bits 27:16.
- R6: A configuration write that lowers enable clears ready and pulses ctl_reset for one cycle. The fatal bit is left as it was.
- R7: A configuration write that makes the shutdown field (bits 15:14) non-zero from zero sets status bits 3:2 to 2'b10. A write that returns it to zero clears them.
- R8: Each admin base is written as two 32-bit halves:
  - submission ring: low half at 0x28, high half at 0x2C;
  - completion ring: low half at 0x30, high half at 0x34.

  Each half reads back as written. The size word keeps all 32 written bits.
- R9: Reads of offsets outside the map return 0. Writes to the capability, version and status offsets change nothing.
- R10: On a successful enable, the block latches the following exports:
  - page_shift = 12 + page exponent;
  - each entry size in bytes = 2^exponent;
  - each ring depth = its size field + 1.

  A failed enable leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (registered when RD_FLOP=1) |
| irq_mask | output | 32 | Current interrupt mask |
| ready | output | 1 | Controller ready status bit |
| admin_start | output | 1 | One-cycle pulse after a successful enable |
| ctl_reset | output | 1 | One-cycle pulse after enable is lowered |
| page_shift | output | 5 | Latched log2 of the memory page size |
| sub_entry_bytes | output | 16 | Latched submission entry size in bytes |
| cmp_entry_bytes | output | 16 | Latched completion entry size in bytes |
| sub_depth | output | 13 | Latched admin submission ring depth |
| cmp_depth | output | 13 | Latched admin completion ring depth |
| sub_base_o | output | 64 | Admin submission ring base |
| cmp_base_o | output | 64 | Admin completion ring base |

## Verification
The bench builds the block with RD_FLOP=1, so every read goes through the registered read path and is sampled one edge after the strobe. All other parameters keep their defaults: page exponents 0 to 4, entry exponents 6 and 4, and 2047 maximum entries. With these values the fixed capability words can be compared against constants. The defaults also make a page exponent of 5 and entry exponents of 7 and 5 reachable as out-of-range cases. Keeping the page exponent at 0 in the good setup lets a 2 KiB offset act as a misaligned base.

// File: rtl/hctl_pkg.sv
package hctl_pkg;
   localparam int QSZ_W = 12;

   // register byte offsets
   localparam int OFF_CAP_LO = 'h00;
   localparam int OFF_CAP_HI = 'h04;
   localparam int OFF_VER    = 'h08;
   localparam int OFF_MSET   = 'h0C;
   localparam int OFF_MCLR   = 'h10;
   localparam int OFF_CFG    = 'h14;
   localparam int OFF_STAT   = 'h1C;
   localparam int OFF_QSIZE  = 'h24;
   localparam int OFF_SUB_LO = 'h28;
   localparam int OFF_SUB_HI = 'h2C;
   localparam int OFF_CMP_LO = 'h30;
   localparam int OFF_CMP_HI = 'h34;

   // configuration word fields
   localparam int CFG_EN      = 0;
   localparam int CFG_PG_LSB  = 7;
   localparam int CFG_SHN_LSB = 14;
   localparam int CFG_SQ_LSB  = 16;
   localparam int CFG_CQ_LSB  = 20;

   // status word fields
   localparam int ST_RDY     = 0;
   localparam int ST_FATAL   = 1;
   localparam int ST_SHN_LSB = 2;

   localparam logic [31:0] VERSION_WORD = 32'h0001_0100;

   function automatic logic [63:0] mk_cap(input logic [15:0] max_ent,
                                          input logic [7:0]  tmo,
                                          input logic [3:0]  pg_min,
                                          input logic [3:0]  pg_max);
      logic [63:0] c;
      c        = '0;
      c[15:0]  = max_ent;
      c[16]    = 1'b1;
      c[31:24] = tmo;
      c[44:37] = 8'h01;
      c[51:48] = pg_min;
      c[55:52] = pg_max;
      return c;
   endfunction
endpackage

// File: rtl/hctl_check.sv
module hctl_check #(
   parameter int PG_MIN  = 0,
   parameter int PG_MAX  = 4,
   parameter int SQ_MIN  = 6,
   parameter int SQ_MAX  = 6,
   parameter int CQ_MIN  = 4,
   parameter int CQ_MAX  = 4,
   parameter int QSZ_W   = 12
) (
   input  logic [3:0]       pg_exp,
   input  logic [3:0]       sq_exp,
   input  logic [3:0]       cq_exp,
   input  logic [QSZ_W-1:0] sub_qsz,
   input  logic [QSZ_W-1:0] cmp_qsz,
   input  logic [63:0]      sub_base,
   input  logic [63:0]      cmp_base,
   output logic             cfg_ok
);
   logic [63:0] pg_mask;
   logic        pg_in, sq_in, cq_in, bases_ok, sizes_ok;

   always_comb begin
      pg_mask  = (64'd1 << (6'd12 + {2'b00, pg_exp})) - 64'd1;
      pg_in    = (int'(pg_exp) >= PG_MIN) && (int'(pg_exp) <= PG_MAX);
      sq_in    = (int'(sq_exp) >= SQ_MIN) && (int'(sq_exp) <= SQ_MAX);
      cq_in    = (int'(cq_exp) >= CQ_MIN) && (int'(cq_exp) <= CQ_MAX);
      bases_ok = (sub_base != '0) && (cmp_base != '0) &&
                 ((sub_base & pg_mask) == '0) && ((cmp_base & pg_mask) == '0);
      sizes_ok = (sub_qsz != '0) && (cmp_qsz != '0);
      cfg_ok   = pg_in && sq_in && cq_in && bases_ok && sizes_ok;
   end
endmodule

// File: rtl/hctl_rdmux.sv
module hctl_rdmux #(
   parameter int          ADDR_W   = 8,
   parameter logic [63:0] CAP_WORD = '0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       mask,
   input  logic [31:0]       cfg,
   input  logic [31:0]       stat,
   input  logic [31:0]       qsize,
   input  logic [63:0]       sub_base,
   input  logic [63:0]       cmp_base,
   output logic [31:0]       rdata
);
   import hctl_pkg::*;

   always_comb begin
      rdata = '0;
      case (int'(addr))
         OFF_CAP_LO: rdata = CAP_WORD[31:0];
         OFF_CAP_HI: rdata = CAP_WORD[63:32];
         OFF_VER:    rdata = VERSION_WORD;
         OFF_MSET:   rdata = mask;
         OFF_MCLR:   rdata = mask;
         OFF_CFG:    rdata = cfg;
         OFF_STAT:   rdata = stat;
         OFF_QSIZE:  rdata = qsize;
         OFF_SUB_LO: rdata = sub_base[31:0];
         OFF_SUB_HI: rdata = sub_base[63:32];
         OFF_CMP_LO: rdata = cmp_base[31:0];
         OFF_CMP_HI: rdata = cmp_base[63:32];
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/hctl_regs.sv
module hctl_regs #(
   parameter int          ADDR_W  = 8,
   parameter int          PG_MIN  = 0,
   parameter int          PG_MAX  = 4,
   parameter int          SQ_MIN  = 6,
   parameter int          SQ_MAX  = 6,
   parameter int          CQ_MIN  = 4,
   parameter int          CQ_MAX  = 4,
   parameter logic [15:0] MAX_ENT = 16'h07FF,
   parameter logic [7:0]  TMO     = 8'h0F,
   parameter bit          RD_FLOP = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_valid,
   input  logic                      bus_write,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [31:0]               bus_wdata,
   output logic [31:0]               bus_rdata,
   output logic [31:0]               irq_mask,
   output logic                      ready,
   output logic                      admin_start,
   output logic                      ctl_reset,
   output logic [4:0]                page_shift,
   output logic [15:0]               sub_entry_bytes,
   output logic [15:0]               cmp_entry_bytes,
   output logic [hctl_pkg::QSZ_W:0]  sub_depth,
   output logic [hctl_pkg::QSZ_W:0]  cmp_depth,
   output logic [63:0]               sub_base_o,
   output logic [63:0]               cmp_base_o
);
   import hctl_pkg::*;

   localparam logic [63:0] CAP_WORD =
      mk_cap(MAX_ENT, TMO, 4'(PG_MIN), 4'(PG_MAX));

   initial begin
      if (ADDR_W < 6) $error("hctl_regs: ADDR_W too small for the map");
      if (PG_MIN > PG_MAX || PG_MAX > 15) $error("hctl_regs: bad page range");
      if (SQ_MIN > SQ_MAX || SQ_MAX > 15) $error("hctl_regs: bad sq range");
      if (CQ_MIN > CQ_MAX || CQ_MAX > 15) $error("hctl_regs: bad cq range");
   end

   logic [31:0] mask_q, cfg_q, stat_q, stat_n, qsize_q;
   logic [63:0] sub_q, cmp_q;
   logic        wr, cfg_wr, en_rise, en_fall, shn_rise, shn_fall, cfg_ok;
   logic [31:0] rd_mux;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
      return a == ADDR_W'(off);
   endfunction

   assign wr       = bus_valid && bus_write;
   assign cfg_wr   = wr && hit(bus_addr, OFF_CFG);
   assign en_rise  = cfg_wr &&  bus_wdata[CFG_EN] && !cfg_q[CFG_EN];
   assign en_fall  = cfg_wr && !bus_wdata[CFG_EN] &&  cfg_q[CFG_EN];
   assign shn_rise = cfg_wr && (bus_wdata[CFG_SHN_LSB+:2] != 2'b00) &&
                     (cfg_q[CFG_SHN_LSB+:2] == 2'b00);
   assign shn_fall = cfg_wr && (bus_wdata[CFG_SHN_LSB+:2] == 2'b00) &&
                     (cfg_q[CFG_SHN_LSB+:2] != 2'b00);

   hctl_check #(
      .PG_MIN(PG_MIN), .PG_MAX(PG_MAX), .SQ_MIN(SQ_MIN), .SQ_MAX(SQ_MAX),
      .CQ_MIN(CQ_MIN), .CQ_MAX(CQ_MAX), .QSZ_W(QSZ_W)
   ) u_check (
      .pg_exp  (bus_wdata[CFG_PG_LSB+:4]),
      .sq_exp  (bus_wdata[CFG_SQ_LSB+:4]),
      .cq_exp  (bus_wdata[CFG_CQ_LSB+:4]),
      .sub_qsz (qsize_q[QSZ_W-1:0]),
      .cmp_qsz (qsize_q[16+:QSZ_W]),
      .sub_base(sub_q),
      .cmp_base(cmp_q),
      .cfg_ok  (cfg_ok)
   );

   always_comb begin
      stat_n = stat_q;
      if (en_rise)      stat_n = cfg_ok ? 32'h1 : 32'h2;
      else if (en_fall) stat_n[ST_RDY] = 1'b0;
      if (shn_rise)      stat_n[ST_SHN_LSB+:2] = 2'b10;
      else if (shn_fall) stat_n[ST_SHN_LSB+:2] = 2'b00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         cfg_q   <= '0;
         stat_q  <= '0;
         qsize_q <= '0;
         sub_q   <= '0;
         cmp_q   <= '0;
      end else begin
         stat_q <= stat_n;
         if (wr) begin
            if (hit(bus_addr, OFF_MSET))   mask_q        <= mask_q | bus_wdata;
            if (hit(bus_addr, OFF_MCLR))   mask_q        <= mask_q & ~bus_wdata;
            if (hit(bus_addr, OFF_CFG))    cfg_q         <= bus_wdata;
            if (hit(bus_addr, OFF_QSIZE))  qsize_q       <= bus_wdata;
            if (hit(bus_addr, OFF_SUB_LO)) sub_q[31:0]   <= bus_wdata;
            if (hit(bus_addr, OFF_SUB_HI)) sub_q[63:32]  <= bus_wdata;
            if (hit(bus_addr, OFF_CMP_LO)) cmp_q[31:0]   <= bus_wdata;
            if (hit(bus_addr, OFF_CMP_HI)) cmp_q[63:32]  <= bus_wdata;
         end
      end
   end

   // pulses and values latched at a good enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         admin_start     <= 1'b0;
         ctl_reset       <= 1'b0;
         page_shift      <= '0;
         sub_entry_bytes <= '0;
         cmp_entry_bytes <= '0;
         sub_depth       <= '0;
         cmp_depth       <= '0;
      end else begin
         admin_start <= en_rise && cfg_ok;
         ctl_reset   <= en_fall;
         if (en_rise && cfg_ok) begin
            page_shift      <= 5'd12 + {1'b0, bus_wdata[CFG_PG_LSB+:4]};
            sub_entry_bytes <= 16'd1 << bus_wdata[CFG_SQ_LSB+:4];
            cmp_entry_bytes <= 16'd1 << bus_wdata[CFG_CQ_LSB+:4];
            sub_depth       <= {1'b0, qsize_q[QSZ_W-1:0]} + 1'b1;
            cmp_depth       <= {1'b0, qsize_q[16+:QSZ_W]} + 1'b1;
         end
      end
   end

   hctl_rdmux #(.ADDR_W(ADDR_W), .CAP_WORD(CAP_WORD)) u_rdmux (
      .addr    (bus_addr),
      .mask    (mask_q),
      .cfg     (cfg_q),
      .stat    (stat_q),
      .qsize   (qsize_q),
      .sub_base(sub_q),
      .cmp_base(cmp_q),
      .rdata   (rd_mux)
   );

   generate
      if (RD_FLOP) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       bus_rdata <= '0;
            else if (bus_valid && !bus_write) bus_rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign bus_rdata = (bus_valid && !bus_write) ? rd_mux : '0;
      end
   endgenerate

   assign irq_mask   = mask_q;
   assign ready      = stat_q[ST_RDY];
   assign sub_base_o = sub_q;
   assign cmp_base_o = cmp_q;
endmodule

// File: rtl/hctl_regs_chk.sv
module hctl_regs_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       irq_mask,
   input logic              ready,
   input logic              admin_start,
   input logic              ctl_reset,
   input logic [31:0]       stat,
   input logic [31:0]       cfg
);
   logic wr_set, wr_clr, wr_off;
   assign wr_set = bus_valid && bus_write && bus_addr == ADDR_W'('h0C);
   assign wr_clr = bus_valid && bus_write && bus_addr == ADDR_W'('h10);
   assign wr_off = bus_valid && bus_write && bus_addr == ADDR_W'('h14) &&
                   cfg[0] && !bus_wdata[0];

   AST_MASK_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((irq_mask & $past(bus_wdata)) == $past(bus_wdata))); // R3
   AST_MASK_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((irq_mask & $past(bus_wdata)) == 32'h0)); // R3
   AST_START_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      admin_start |-> ready); // R4
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      admin_start |=> !admin_start); // R4
   AST_READY_FATAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat[0] && stat[1])); // R5
   AST_NO_START_ON_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
      stat[1] |-> !admin_start); // R5
   AST_DISABLE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_off |=> (!ready && ctl_reset)); // R6
endmodule

bind hctl_regs hctl_regs_chk #(.ADDR_W(ADDR_W)) u_regs_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_mask(irq_mask),
   .ready(ready), .admin_start(admin_start), .ctl_reset(ctl_reset),
   .stat(stat_q), .cfg(cfg_q)
);

// File: tb/test_hctl_regs.sv
`timescale 1ns/1ps
module test_hctl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, irq_mask;
   logic        ready, admin_start, ctl_reset;
   logic [4:0]  page_shift;
   logic [15:0] sub_entry_bytes, cmp_entry_bytes;
   logic [12:0] sub_depth, cmp_depth;
   logic [63:0] sub_base_o, cmp_base_o;

   int nchk = 0, nerr = 0, starts = 0;
   bit done = 0;

   always #4 clk = ~clk;

   hctl_regs #(.RD_FLOP(1'b1)) i_hctl_regs (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_mask(irq_mask), .ready(ready), .admin_start(admin_start),
      .ctl_reset(ctl_reset), .page_shift(page_shift),
      .sub_entry_bytes(sub_entry_bytes), .cmp_entry_bytes(cmp_entry_bytes),
      .sub_depth(sub_depth), .cmp_depth(cmp_depth),
      .sub_base_o(sub_base_o), .cmp_base_o(cmp_base_o)
   );

   always @(posedge clk) if (admin_start) starts++;

   localparam logic [31:0] GOOD_CFG = 32'h0046_0001;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h1C, v); chk("R1 status", v, 0);
      rd(8'h14, v); chk("R1 config", v, 0);
      rd(8'h0C, v); chk("R1 mask", v, 0);
      rd(8'h24, v); chk("R1 qsize", v, 0);
      chk("R1 bases", {sub_base_o | cmp_base_o}, 0);
      chk("R1 pulses", {ready, admin_start, ctl_reset}, 0);
   endtask

   task automatic t_ident();
      logic [31:0] v;
      rd(8'h00, v); chk("R2 cap lo", v, 32'h0F01_07FF);
      rd(8'h04, v); chk("R2 cap hi", v, 32'h0040_0020);
      rd(8'h08, v); chk("R2 version", v, 32'h0001_0100);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      wr(8'h0C, 32'h0000_F0F0);
      rd(8'h0C, v); chk("R3 set read", v, 32'h0000_F0F0);
      rd(8'h10, v); chk("R3 clr alias", v, 32'h0000_F0F0);
      wr(8'h0C, 32'h0000_000F);
      chk("R3 set or", irq_mask, 32'h0000_F0FF);
      wr(8'h10, 32'h0000_F000);
      rd(8'h10, v); chk("R3 clear", v, 32'h0000_00FF);
   endtask

   task automatic t_bases();
      logic [31:0] v;
      wr(8'h28, 32'h0000_3000); wr(8'h2C, 32'h0000_0001);
      wr(8'h30, 32'h0000_5000); wr(8'h34, 32'h0000_0000);
      wr(8'h24, 32'h001F_0007);
      rd(8'h2C, v); chk("R8 sub hi", v, 32'h1);
      rd(8'h28, v); chk("R8 sub lo", v, 32'h3000);
      rd(8'h30, v); chk("R8 cmp lo", v, 32'h5000);
      chk("R8 sub base", sub_base_o, 64'h1_0000_3000);
      rd(8'h24, v); chk("R8 qsize", v, 32'h001F_0007);
   endtask

   task automatic t_start();
      logic [31:0] v;
      int s0;
      s0 = starts;
      wr(8'h14, GOOD_CFG);
      chk("R4 start pulse", admin_start, 1);
      chk("R4 ready", ready, 1);
      @(negedge clk);
      chk("R4 start one cycle", admin_start, 0);
      chk("R4 pulse count", starts - s0, 1);
      rd(8'h1C, v); chk("R4 status", v, 32'h1);
      chk("R10 page shift", page_shift, 12);
      chk("R10 entry bytes", {sub_entry_bytes, cmp_entry_bytes}, {16'd64, 16'd16});
      chk("R10 depths", {sub_depth, cmp_depth}, {13'd8, 13'd32});
   endtask

   task automatic t_shutdown();
      logic [31:0] v;
      wr(8'h14, GOOD_CFG | 32'h4000);
      rd(8'h1C, v); chk("R7 shutdown done", v, 32'h9);
      wr(8'h14, GOOD_CFG);
      rd(8'h1C, v); chk("R7 shutdown cleared", v, 32'h1);
   endtask

   task automatic t_disable();
      logic [31:0] v;
      wr(8'h14, 32'h0);
      chk("R6 reset pulse", ctl_reset, 1);
      chk("R6 ready low", ready, 0);
      @(negedge clk);
      chk("R6 reset one cycle", ctl_reset, 0);
      rd(8'h1C, v); chk("R6 status", v, 32'h0);
   endtask

   task automatic try_bad(input string req, input logic [31:0] cfg);
      logic [31:0] v;
      int s0;
      s0 = starts;
      wr(8'h14, cfg);
      @(negedge clk);
      rd(8'h1C, v); chk(req, v, 32'h2);
      chk({req, " no start"}, starts - s0, 0);
      wr(8'h14, 32'h0);
   endtask

   task automatic t_fail();
      logic [31:0] v;
      try_bad("R5 page exp", 32'h0046_0281);
      chk("R10 kept after fail", page_shift, 12);
      try_bad("R5 sub exp", 32'h0047_0001);
      try_bad("R5 cmp exp", 32'h0056_0001);
      wr(8'h30, 32'h0000_5800);
      try_bad("R5 misaligned", GOOD_CFG);
      wr(8'h30, 32'h0000_5000);
      wr(8'h28, 32'h0); wr(8'h2C, 32'h0);
      try_bad("R5 zero base", GOOD_CFG);
      wr(8'h28, 32'h0000_3000);
      wr(8'h24, 32'h001F_0000);
      try_bad("R5 zero size", GOOD_CFG);
      wr(8'h24, 32'h0003_0001);
      wr(8'h14, GOOD_CFG);
      rd(8'h1C, v); chk("R4 recover", v, 32'h1);
      chk("R10 new depths", {sub_depth, cmp_depth}, {13'd2, 13'd4});
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      rd(8'h18, v); chk("R9 hole", v, 0);
      rd(8'h40, v); chk("R9 beyond", v, 0);
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, v); chk("R9 cap ro", v, 32'h0F01_07FF);
      wr(8'h1C, 32'h0000_00FF);
      rd(8'h1C, v); chk("R9 status ro", v, 32'h1);
      wr(8'h08, 32'h0);
      rd(8'h08, v); chk("R9 version ro", v, 32'h0001_0100);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ident();
      t_mask();
      t_bases();
      t_start();
      t_shutdown();
      t_disable();
      t_fail();
      t_unmapped();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++; nerr++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule